// File: doc/BRIEF.md
# Atomic Wide Register Bridge

This block lets an 8-bit processor bus reach peripheral registers that are 16, 24 or 32 bits wide without ever seeing, or leaving behind, a half-updated value. A small set of shared shadow bytes holds the partial data while the bus steps through a wide register one byte at a time. The whole value then moves in a single clock edge.

On a write, every byte below the most significant one only lands in its shadow slot. The write of the most significant byte drives a one-cycle commit strobe to the peripheral, carrying the full word built from the shadow bytes and the incoming byte. On a read, the access to byte 0 returns the live low byte and, at that same edge, freezes the live upper bytes into the shadow slots. Later byte reads return that frozen copy, even if the peripheral value has moved on. The shadow slots also have their own addresses, so software can save and restore them. Nothing guards a sequence against a nested access to another wide register, which software must prevent.

Each wide register k takes a four-byte window starting at address 4k, with the least significant byte at the lowest address. With the default parameters, register 0 is 16 bits wide (addresses 0–1), register 1 is 24 bits wide (4–6) and register 2 is 32 bits wide (8–11). The three shadow bytes sit at addresses 12, 13 and 14.

Top module: `wide_reg_bridge`

## Requirements
- R1: A write to byte i of register k (address 4k+i), where i is below the register's top byte, stores the data in shadow slot i and raises no commit strobe.
- R2: A write to the top byte of register k raises regWrStb[k] in that same cycle, and only that bit. The 32-bit slice k of regWrData holds the written byte at the top byte position, shadow slot j at byte j below it, and zero above it.
- R3: A read of byte 0 of register k returns live byte 0 in the same cycle. At that edge, live bytes 1 and up are copied into shadow slots 0 and up.
- R4: A read of byte i ≥ 1 of register k returns shadow slot i−1, not the current live value.
- R5: A byte-0 read copies only as many bytes as the register has above byte 0. Shadow slots beyond that keep their values.
- R6: Address 12+j (j = 0..2) reads and writes shadow slot j directly, without a commit.
- R7: An address outside every window and outside the shadow range reads as 0. A write to it changes no shadow slot and raises no strobe. Address 15 and addresses 2–3, 7 and 16–31 are such addresses.
- R8: After reset, all shadow slots are 0 and no strobe is raised.
- R9: The shadow slots are shared by all registers. A low-byte write to another register during a sequence overwrites the pending byte, and the later commit carries the overwritten value.
- R10: busRdData is 0 in every cycle where busRd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 5 | Byte address |
| busWrData | input | 8 | Write byte |
| busWr | input | 1 | Write strobe, one byte per cycle |
| busRd | input | 1 | Read strobe, one byte per cycle |
| busRdData | output | 8 | Read byte, valid in the strobe cycle |
| regWrStb | output | 3 | Commit strobe per wide register |
| regWrData | output | 96 | Committed word, 32 bits per register |
| regRdData | input | 96 | Live peripheral values, 32 bits per register |

## Verification
The checks assume that the bus never asserts busWr and busRd in the same cycle. They also assume that the live values are stable around each clock edge. The stimulus keeps to this: it drives exactly one operation, or an idle cycle, per clock, and it changes the live values only together with a new operation. The checks also take it as given that a wide sequence is not interrupted unless a test does so on purpose. The interleaving test for R9 is the one case that breaks a sequence, and its expected values are computed for exactly that corruption.

// File: rtl/wab_pkg.sv
package wab_pkg;
  localparam int MAX_BYTES = 4;
  localparam int TEMP_N = MAX_BYTES - 1;

  typedef enum logic [1:0] {RD_NONE, RD_LIVE0, RD_TEMP} rdSel_e;

  typedef struct packed {
    logic       tempLoad;
    logic [1:0] tempIdx;
    logic       snapshot;
    logic       commit;
    logic [7:0] regIdx;
    logic [1:0] span;
    rdSel_e     rdSel;
  } ctl_t;
endpackage

// File: rtl/wab_ctrl.sv
module wab_ctrl #(
  parameter int ADDR_W = 5,
  parameter int NUM_REGS = 3,
  parameter int unsigned REG_BYTES [NUM_REGS] = '{2, 3, 4},
  parameter int TEMP_BASE = 12
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output wab_pkg::ctl_t     ctl
);
  import wab_pkg::*;

  localparam int BYTE_W = $clog2(MAX_BYTES);

  logic [ADDR_W-BYTE_W-1:0] winIdx;
  logic [BYTE_W-1:0]        byteIdx;
  int                       addrInt;

  assign winIdx  = busAddr[ADDR_W-1:BYTE_W];
  assign byteIdx = busAddr[BYTE_W-1:0];
  assign addrInt = int'(busAddr);

  always_comb begin
    ctl = '0;
    ctl.rdSel = RD_NONE;
    if (addrInt >= TEMP_BASE && addrInt < TEMP_BASE + TEMP_N) begin
      ctl.tempIdx  = 2'(addrInt - TEMP_BASE);
      ctl.tempLoad = busWr;
      if (busRd) ctl.rdSel = RD_TEMP;
    end else begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if (int'(winIdx) == k && int'(byteIdx) < int'(REG_BYTES[k])) begin
          ctl.regIdx = 8'(k);
          ctl.span   = 2'(REG_BYTES[k] - 1);
          if (busWr) begin
            if (int'(byteIdx) == int'(REG_BYTES[k]) - 1) ctl.commit = 1'b1;
            else begin
              ctl.tempLoad = 1'b1;
              ctl.tempIdx  = 2'(byteIdx);
            end
          end
          if (busRd) begin
            if (byteIdx == '0) begin
              ctl.snapshot = 1'b1;
              ctl.rdSel    = RD_LIVE0;
            end else begin
              ctl.rdSel   = RD_TEMP;
              ctl.tempIdx = 2'(int'(byteIdx) - 1);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/wab_datapath.sv
module wab_datapath #(
  parameter int NUM_REGS = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  wab_pkg::ctl_t           ctl,
  input  logic [7:0]              wrData,
  input  logic [NUM_REGS*32-1:0]  liveFlat,
  output logic [7:0]              rdData,
  output logic [31:0]             commitData
);
  import wab_pkg::*;

  logic [7:0]  temp [TEMP_N];
  logic [31:0] liveSel;

  always_comb begin
    liveSel = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (ctl.regIdx == 8'(k)) liveSel = liveFlat[k*32 +: 32];
  end

  for (genvar j = 0; j < TEMP_N; j++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) temp[j] <= '0;
      else if (ctl.tempLoad && ctl.tempIdx == 2'(j)) temp[j] <= wrData;
      else if (ctl.snapshot && j < int'(ctl.span)) temp[j] <= liveSel[8*(j+1) +: 8];
    end

    // R1: a staged byte lands in its own slot
    p_temp_load_r1: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.tempLoad && ctl.tempIdx == 2'(j)) |=> temp[j] == $past(wrData));
  end

  always_comb begin
    commitData = '0;
    for (int b = 0; b < TEMP_N; b++)
      if (b < int'(ctl.span)) commitData[8*b +: 8] = temp[b];
    for (int b = 0; b < MAX_BYTES; b++)
      if (b == int'(ctl.span)) commitData[8*b +: 8] = wrData;
  end

  always_comb begin
    unique case (ctl.rdSel)
      RD_LIVE0: rdData = liveSel[7:0];
      RD_TEMP:  rdData = temp[ctl.tempIdx];
      default:  rdData = '0;
    endcase
  end

  p_snap_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.snapshot && ctl.span != 2'd0 && !ctl.tempLoad) |=> temp[0] == $past(liveSel[15:8]));

  p_snap_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.snapshot && ctl.span == 2'd1 && !ctl.tempLoad) |=> temp[TEMP_N-1] == $past(temp[TEMP_N-1]));
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge #(
  parameter int ADDR_W = 5,
  parameter int NUM_REGS = 3,
  parameter int unsigned REG_BYTES [NUM_REGS] = '{2, 3, 4}
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [7:0]             busWrData,
  input  logic                   busWr,
  input  logic                   busRd,
  output logic [7:0]             busRdData,
  output logic [NUM_REGS-1:0]    regWrStb,
  output logic [NUM_REGS*32-1:0] regWrData,
  input  logic [NUM_REGS*32-1:0] regRdData
);
  import wab_pkg::*;

  localparam int TEMP_BASE = NUM_REGS * MAX_BYTES;

  ctl_t        ctl;
  logic [31:0] commitData;

  wab_ctrl #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES), .TEMP_BASE(TEMP_BASE)
  ) u_ctrl (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .ctl(ctl)
  );

  wab_datapath #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(busWrData),
    .liveFlat(regRdData), .rdData(busRdData), .commitData(commitData)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_port
    assign regWrStb[k]              = ctl.commit && ctl.regIdx == 8'(k);
    assign regWrData[k*32 +: 32]    = commitData;
  end

  p_commit_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regWrStb));

  p_no_early_commit_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == '0) |-> regWrStb == '0);

  p_rd_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> busRdData == 8'd0);

  p_temp_direct_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == ADDR_W'(TEMP_BASE) && $past(busWr && busAddr == ADDR_W'(TEMP_BASE)))
      |-> busRdData == $past(busWrData));
endmodule

// File: tb/wide_reg_bridge_bench.sv
module wide_reg_bridge_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busRdData;
  logic [2:0]  regWrStb;
  logic [95:0] regWrData;
  logic [95:0] regRdData = '0;

  int total = 0;
  int bad = 0;
  int nb [3] = '{2, 3, 4};
  logic [7:0] tmp [3] = '{8'h00, 8'h00, 8'h00};

  always #5 clk = ~clk;

  wide_reg_bridge u_wide_reg_bridge (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .busRdData(busRdData),
    .regWrStb(regWrStb), .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit w, input bit r, input int a, input logic [7:0] d,
                      input string req, input bit newLive = 0, input logic [95:0] live = '0);
    int k, i;
    bit mapped, isTemp;
    logic [7:0] expRd;
    logic [2:0] expStb;
    logic [31:0] expWord;
    @(posedge clk); #1;
    busWr = w; busRd = r; busAddr = 5'(a); busWrData = d;
    if (newLive) regRdData = live;
    #4;
    k = a / 4; i = a % 4;
    mapped = (a < 12) && (i < nb[k]);
    isTemp = (a >= 12) && (a < 15);
    expRd = 8'h00; expStb = '0; expWord = '0;
    if (r) begin
      if (isTemp) expRd = tmp[a-12];
      else if (mapped) expRd = (i == 0) ? regRdData[k*32 +: 8] : tmp[i-1];
    end
    if (w && mapped && i == nb[k] - 1) begin
      expStb[k] = 1'b1;
      expWord = 32'(d) << (8 * i);
      for (int j = 0; j < i; j++) expWord = expWord | (32'(tmp[j]) << (8 * j));
    end
    check(req, "busRdData", 32'(busRdData), 32'(expRd));
    check(req, "regWrStb", 32'(regWrStb), 32'(expStb));
    if (expStb != 0) check(req, "regWrData", regWrData[k*32 +: 32], expWord);
    if (w) begin
      if (isTemp) tmp[a-12] = d;
      else if (mapped && i < nb[k] - 1) tmp[i] = d;
    end
    if (r && mapped && i == 0)
      for (int j = 0; j < nb[k] - 1; j++) tmp[j] = regRdData[k*32 + 8*(j+1) +: 8];
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R8: reset state
    step(0, 0, 0, 8'h00, "R8");
    step(0, 1, 12, 8'h00, "R8");
    step(0, 1, 13, 8'h00, "R8");
    step(0, 1, 14, 8'h00, "R8");
    // R1, R2: 16-bit and 32-bit write sequences
    step(1, 0, 0, 8'hA5, "R1");
    step(1, 0, 1, 8'h3C, "R2");
    step(1, 0, 8, 8'h11, "R1");
    step(1, 0, 9, 8'h22, "R1");
    step(1, 0, 10, 8'h33, "R1");
    step(1, 0, 11, 8'h44, "R2");
    step(1, 0, 4, 8'hC1, "R1");
    step(1, 0, 5, 8'hC2, "R1");
    step(1, 0, 6, 8'hC3, "R2");
    // R3, R4: snapshot holds while live value moves
    step(0, 1, 8, 8'h00, "R3", 1, {32'hDEADBEEF, 32'h00CAFE77, 32'h0000ABCD});
    step(0, 1, 9, 8'h00, "R4", 1, {32'h01020304, 32'h00050607, 32'h00000809});
    step(0, 1, 10, 8'h00, "R4", 1, {32'hFFFFFFFF, 32'h00FFFFFF, 32'h0000FFFF});
    step(0, 1, 11, 8'h00, "R4");
    step(0, 1, 4, 8'h00, "R3", 1, {32'h10203040, 32'h00556677, 32'h00009988});
    step(0, 1, 5, 8'h00, "R4", 1, {32'h0, 32'h0, 32'h0});
    step(0, 1, 6, 8'h00, "R4");
    // R5: 16-bit snapshot leaves upper slots alone
    step(1, 0, 14, 8'h5A, "R6");
    step(1, 0, 13, 8'h6B, "R6");
    step(0, 1, 0, 8'h00, "R3", 1, {32'h0, 32'h0, 32'h0000E1F2});
    step(0, 1, 14, 8'h00, "R5");
    step(0, 1, 13, 8'h00, "R5");
    step(0, 1, 1, 8'h00, "R4");
    // R6: direct shadow access
    step(1, 0, 12, 8'h77, "R6");
    step(0, 1, 12, 8'h00, "R6");
    step(1, 0, 1, 8'h99, "R6");
    // R7: unmapped addresses
    step(1, 0, 15, 8'hEE, "R7");
    step(1, 0, 3, 8'hEE, "R7");
    step(1, 0, 7, 8'hEE, "R7");
    step(1, 0, 20, 8'hEE, "R7");
    step(0, 1, 15, 8'h00, "R7");
    step(0, 1, 2, 8'h00, "R7");
    step(0, 1, 31, 8'h00, "R7");
    step(0, 1, 12, 8'h00, "R7");
    step(0, 1, 13, 8'h00, "R7");
    step(0, 1, 14, 8'h00, "R7");
    // R9: interleaved access corrupts a pending sequence
    step(1, 0, 8, 8'h81, "R9");
    step(1, 0, 9, 8'h82, "R9");
    step(1, 0, 0, 8'hF0, "R9");
    step(1, 0, 10, 8'h83, "R9");
    step(1, 0, 11, 8'h84, "R9");
    // R10: idle cycles
    step(0, 0, 8, 8'h00, "R10");
    step(1, 0, 20, 8'h12, "R10");
    // mixed traffic
    for (int n = 0; n < 60; n++) begin
      int a;
      int op;
      a = int'($urandom_range(0, 31));
      op = int'($urandom_range(0, 2));
      step(op == 1, op == 2, a, 8'($urandom), "R2",
           ($urandom_range(0, 1) == 1), {$urandom, $urandom, $urandom});
    end
    @(posedge clk); #1;
    busWr = 0; busRd = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule